// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic use an external asynchronous static RAM that holds one bit per word and has a 20-bit address. The RAM has a data line in and a data line out, and it is driven by an active-low select and an active-low write strobe. On the host side, one request at a time is accepted through a valid/ready handshake. A read returns its bit on `rd_data` together with a single-cycle `rd_valid` strobe.

Every timing interval of the RAM is a parameter in nanoseconds, together with the clock period. The controller rounds each interval up to whole clock cycles, so one netlist can be built for any speed grade. A write is controlled by the write strobe and has three counted phases: setup, pulse and hold. A read keeps the RAM selected for one read-cycle time and samples the data pin on the last cycle of that count.

A retention request from the host places the RAM in its low-power retention standby with the select held high. When the request is released, the controller waits out a full read-cycle recovery before it accepts the next access.

Top module: `sram_ctl`

## Requirements
- R1: During and after reset `ram_ce_n` and `ram_we_n` are high, `rd_valid` is low, and the controller is idle, with `req_ready` high whenever `retain_req` is low.
- R2: `req_ready` is high only while idle with `retain_req` low. A request is taken on a clock edge where `req_valid` and `req_ready` are both high (`req_we`=1 means write). While `req_ready` is high, `ram_ce_n` and `ram_we_n` are both high.
- R3: When a write is taken, `ram_ce_n` falls at the same edge that presents the address and data. `ram_we_n` falls AS_CYC = max(1, ceil(T_AS/clk)) cycles later. Address and data do not change while `ram_we_n` is low, and `ram_we_n` is never low while `ram_ce_n` is high.
- R4: `ram_we_n` stays low for exactly WP_CYC = max(1, ceil(T_WP/clk), ceil(T_DS/clk)) cycles, so both the pulse width and the data setup before its rising edge are met.
- R5: After `ram_we_n` rises, address, data and `ram_ce_n` low are held for HD_CYC = max(1, ceil(T_AH/clk), ceil(T_WC/clk) - AS_CYC - WP_CYC) cycles. A write therefore keeps `req_ready` low for AS_CYC + WP_CYC + HD_CYC cycles.
- R6: A read holds `ram_ce_n` low and `ram_we_n` high, with a stable address, for RC_CYC = max(1, ceil(T_RC/clk)) cycles. `ram_dout` is sampled at the edge that ends the last of those cycles, so the returned bit equals the value last written to that address (0 if never written).
- R7: `rd_valid` is a one-cycle pulse at the edge that ends the read. `rd_data` keeps its value until the next read completes, and `req_ready` returns at that same edge.
- R8: A `retain_req` seen at an idle edge enters retention. `req_ready` is low while `retain_req` is high, and `ram_ce_n` stays high for the whole retention period.
- R9: After `retain_req` is seen low in retention, `req_ready` stays low for RC_CYC cycles, and no access starts less than one read-cycle time after the release.
- R10: `retain_req` raised while an access is in progress has no effect on that access. Retention is entered at the first idle edge where it is still high.
- R11: Between two accesses `ram_ce_n` returns high for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 1 | Bit to write |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | 1 | Bit returned by the last read |
| retain_req | input | 1 | Request low-power retention standby |
| ram_addr | output | ADDR_W | RAM address |
| ram_din | output | 1 | RAM data input line |
| ram_dout | input | 1 | RAM data output line |
| ram_ce_n | output | 1 | RAM select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |

## Verification
The assertions assume that `req_valid`, `req_we`, `req_addr`, `req_wdata` and `retain_req` are synchronous to `clk` and settled before each rising edge. They also assume that `ram_dout` is settled by the edge on which the read is sampled. The bench changes every host input only on the falling clock edge. It draws addresses from a small set that includes both ends of the address space, so reads hit earlier writes. Its behavioural RAM updates the data pin only between edges and returns the inverted bit until a full access time has passed since the last address or select change, so sampling one cycle early yields a wrong value.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int ADDR_W  = 20,
  parameter int CLK_NS  = 10,
  parameter int T_RC_NS = 20,
  parameter int T_WC_NS = 20,
  parameter int T_WP_NS = 15,
  parameter int T_DS_NS = 8,
  parameter int T_AS_NS = 0,
  parameter int T_AH_NS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  output logic              rd_valid,
  output logic              rd_data,
  input  logic              retain_req,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_din,
  input  logic              ram_dout,
  output logic              ram_ce_n,
  output logic              ram_we_n
);

  localparam int RC_RAW = (T_RC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC_RAW = (T_WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int WP_RAW = (T_WP_NS + CLK_NS - 1) / CLK_NS;
  localparam int DS_RAW = (T_DS_NS + CLK_NS - 1) / CLK_NS;
  localparam int AS_RAW = (T_AS_NS + CLK_NS - 1) / CLK_NS;
  localparam int AH_RAW = (T_AH_NS + CLK_NS - 1) / CLK_NS;

  localparam int RC_CYC = (RC_RAW < 1) ? 1 : RC_RAW;
  localparam int AS_CYC = (AS_RAW < 1) ? 1 : AS_RAW;
  localparam int WP_A   = (WP_RAW > DS_RAW) ? WP_RAW : DS_RAW;
  localparam int WP_CYC = (WP_A < 1) ? 1 : WP_A;
  localparam int HD_A   = (AH_RAW < 1) ? 1 : AH_RAW;
  localparam int HD_B   = WC_RAW - AS_CYC - WP_CYC;
  localparam int HD_CYC = (HD_B > HD_A) ? HD_B : HD_A;

  localparam int MAX_1  = (RC_CYC > AS_CYC) ? RC_CYC : AS_CYC;
  localparam int MAX_2  = (WP_CYC > HD_CYC) ? WP_CYC : HD_CYC;
  localparam int MAXC   = (MAX_1 > MAX_2) ? MAX_1 : MAX_2;
  localparam int CNT_W  = $clog2(MAXC + 1) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_WSET, S_WPUL, S_WHLD, S_RET, S_REC
  } state_t;

  state_t state;
  logic [CNT_W-1:0] cnt;
  logic cnt_done;

  assign cnt_done  = (cnt == '0);
  assign req_ready = (state == S_IDLE) && !retain_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ram_ce_n <= 1'b1;
      ram_we_n <= 1'b1;
      ram_addr <= '0;
      ram_din  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (retain_req) begin
            state <= S_RET;
          end else if (req_valid) begin
            ram_addr <= req_addr;
            ram_din  <= req_wdata;
            ram_ce_n <= 1'b0;
            if (req_we) begin
              state <= S_WSET;
              cnt   <= CNT_W'(AS_CYC - 1);
            end else begin
              state <= S_READ;
              cnt   <= CNT_W'(RC_CYC - 1);
            end
          end
        end
        S_READ: begin
          if (cnt_done) begin
            rd_data  <= ram_dout;
            rd_valid <= 1'b1;
            ram_ce_n <= 1'b1;
            state    <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WSET: begin
          if (cnt_done) begin
            ram_we_n <= 1'b0;
            state    <= S_WPUL;
            cnt      <= CNT_W'(WP_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WPUL: begin
          if (cnt_done) begin
            ram_we_n <= 1'b1;
            state    <= S_WHLD;
            cnt      <= CNT_W'(HD_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WHLD: begin
          if (cnt_done) begin
            ram_ce_n <= 1'b1;
            state    <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_RET: begin
          if (!retain_req) begin
            state <= S_REC;
            cnt   <= CNT_W'(RC_CYC - 1);
          end
        end
        S_REC: begin
          if (cnt_done) state <= S_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W-1:0] we_low_run;
  always_ff @(posedge clk) begin
    if (!rst_n)         we_low_run <= '0;
    else if (!ram_we_n) we_low_run <= we_low_run + 1'b1;
    else                we_low_run <= '0;
  end

  assert_ready_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && ram_we_n));

  assert_we_needs_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> !ram_ce_n);

  assert_wr_bus_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ($stable(ram_addr) && $stable(ram_din)));

  assert_we_after_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> $past(!ram_ce_n));

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_low_run == CNT_W'(WP_CYC)));

  assert_read_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(!ram_ce_n && ram_we_n));

  assert_rdv_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: tb/sram_ctl_test.sv
`timescale 1ns/1ps
module sram_ctl_test;
  localparam int CLK_NS = 10;
  localparam int TRC = 20, TWC = 20, TWP = 15, TDS = 8, TAS = 0, TAH = 1;
  localparam int RC = ((TRC + CLK_NS - 1) / CLK_NS < 1) ? 1 : (TRC + CLK_NS - 1) / CLK_NS;
  localparam int AS = ((TAS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (TAS + CLK_NS - 1) / CLK_NS;
  localparam int WPa = (TWP + CLK_NS - 1) / CLK_NS;
  localparam int DSa = (TDS + CLK_NS - 1) / CLK_NS;
  localparam int WP = (WPa > DSa) ? WPa : DSa;
  localparam int HDb = (TWC + CLK_NS - 1) / CLK_NS - AS - WP;
  localparam int HDa = ((TAH + CLK_NS - 1) / CLK_NS < 1) ? 1 : (TAH + CLK_NS - 1) / CLK_NS;
  localparam int HD = (HDb > HDa) ? HDb : HDa;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, req_wdata = 0, retain_req = 0;
  logic [19:0] req_addr = '0;
  logic req_ready, rd_valid, rd_data, ram_din, ram_ce_n, ram_we_n;
  logic [19:0] ram_addr;
  logic ram_dout = 0;

  sram_ctl #(.ADDR_W(20), .CLK_NS(CLK_NS), .T_RC_NS(TRC), .T_WC_NS(TWC), .T_WP_NS(TWP),
             .T_DS_NS(TDS), .T_AS_NS(TAS), .T_AH_NS(TAH)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .retain_req(retain_req),
    .ram_addr(ram_addr), .ram_din(ram_din), .ram_dout(ram_dout),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n));

  always #(CLK_NS / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Reference model of the host-side behaviour, advanced on every rising edge
  int cyc = 0, busy = 0, rel_cyc = -1000;
  bit in_ret = 0, pend_rd = 0, exp_rdv = 0, exp_rdd = 0;
  logic [19:0] pend_a;
  bit exp_mem [int];
  bit ram_mem [int];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      busy = 0; in_ret = 0; pend_rd = 0; exp_rdv = 0;
    end else begin
      exp_rdv = 0;
      if (busy > 0) begin
        busy--;
        if (busy == 0 && pend_rd) begin
          exp_rdv = 1;
          exp_rdd = exp_mem.exists(int'(pend_a)) ? exp_mem[int'(pend_a)] : 1'b0;
          pend_rd = 0;
        end
      end else if (in_ret) begin
        if (!retain_req) begin in_ret = 0; busy = RC; rel_cyc = cyc; end
      end else if (retain_req) begin
        in_ret = 1;
      end else if (req_valid) begin
        if (req_we) begin exp_mem[int'(req_addr)] = req_wdata; busy = AS + WP + HD; end
        else begin pend_rd = 1; pend_a = req_addr; busy = RC; end
      end
    end
  end

  // Behavioural RAM with timing checks, updated between edges
  logic p_ce = 1, p_we = 1, p_din = 0;
  logic [19:0] p_addr = '0;
  int addr_chg = -1000, din_chg = -1000, ce_fall = -1000, we_fall = -1000, we_rise = -1000;
  bit wrote = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ce = ram_ce_n; p_we = ram_we_n; p_addr = ram_addr; p_din = ram_din;
      ram_dout = 0;
    end else begin
      if (ram_addr != p_addr) begin
        check(p_we && ram_we_n, "R3", "address moved with write strobe low", 0, 1);
        if (wrote) begin
          check((cyc - we_rise) * CLK_NS >= TAH, "R5", "address hold ns", (cyc - we_rise) * CLK_NS, TAH);
          check((cyc - addr_chg) * CLK_NS >= TWC, "R5", "write cycle ns", (cyc - addr_chg) * CLK_NS, TWC);
        end
        addr_chg = cyc; wrote = 0;
      end
      if (ram_din != p_din) begin
        check(p_we && ram_we_n, "R3", "data moved with write strobe low", 0, 1);
        check(cyc != we_rise, "R5", "data changed at strobe rise", 1, 0);
        din_chg = cyc;
      end
      if (!ram_we_n && ram_ce_n) check(0, "R3", "write strobe low while deselected", 1, 0);
      if (p_we && !ram_we_n) begin
        check(addr_chg < cyc && ce_fall < cyc, "R3", "strobe fell with address/select", cyc - addr_chg, 1);
        we_fall = cyc;
      end
      if (!p_we && ram_we_n) begin
        check((cyc - we_fall) * CLK_NS >= TWP, "R4", "write pulse ns", (cyc - we_fall) * CLK_NS, TWP);
        check((cyc - din_chg) * CLK_NS >= TDS, "R4", "data setup ns", (cyc - din_chg) * CLK_NS, TDS);
        check(!ram_ce_n, "R5", "select held after strobe rise", ram_ce_n, 0);
        ram_mem[int'(p_addr)] = p_din;
        wrote = 1; we_rise = cyc;
      end
      if (p_ce && !ram_ce_n) begin
        ce_fall = cyc;
        check((cyc - rel_cyc) * CLK_NS >= TRC, "R9", "access after retention release ns",
              (cyc - rel_cyc) * CLK_NS, TRC);
      end
      if (in_ret) check(ram_ce_n, "R8", "select high in retention", ram_ce_n, 1);
      if (!ram_ce_n && ram_we_n) begin
        automatic int last = (addr_chg > ce_fall) ? addr_chg : ce_fall;
        automatic bit v = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 1'b0;
        ram_dout = ((cyc + 1 - last) * CLK_NS >= TRC) ? v : ~v;
      end else begin
        ram_dout = 0;
      end
      p_ce = ram_ce_n; p_we = ram_we_n; p_addr = ram_addr; p_din = ram_din;
    end
  end

  task automatic step(input bit v, input bit w, input logic [19:0] a, input bit d, input bit ret);
    @(negedge clk);
    check(req_ready == (busy == 0 && !in_ret && !retain_req), "R2 R9 R10", "req_ready",
          req_ready, (busy == 0 && !in_ret && !retain_req));
    check(rd_valid == exp_rdv, "R7", "rd_valid", rd_valid, exp_rdv);
    if (exp_rdv) check(rd_data == exp_rdd, "R6", "rd_data", rd_data, exp_rdd);
    req_valid = v; req_we = w; req_addr = a; req_wdata = d; retain_req = ret;
  endtask

  function automatic logic [19:0] pick(input int k);
    case (k)
      0: return 20'h00000; 1: return 20'hFFFFF; 2: return 20'h00001; 3: return 20'h80000;
      4: return 20'h5A5A5; 5: return 20'h7FFFF; 6: return 20'h12345; default: return 20'hFFFFE;
    endcase
  endfunction

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(ram_ce_n && ram_we_n && !rd_valid, "R1", "outputs in reset", {ram_ce_n, ram_we_n, rd_valid}, 3'b110);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check(ram_ce_n && ram_we_n && req_ready && !rd_valid, "R1", "idle after reset",
          {ram_ce_n, ram_we_n, req_ready, rd_valid}, 4'b1110);
    // R3 R4 R5: writes at both ends of the address space, R6 reads back
    step(1, 1, 20'h00000, 1, 0); repeat (AS + WP + HD) step(0, 0, 0, 0, 0);
    step(1, 1, 20'hFFFFF, 1, 0); repeat (AS + WP + HD) step(0, 0, 0, 0, 0);
    step(1, 0, 20'h00000, 0, 0); repeat (RC) step(0, 0, 0, 0, 0);
    step(1, 0, 20'hFFFFF, 0, 0); repeat (RC) step(0, 0, 0, 0, 0);
    step(1, 0, 20'h00333, 0, 0); repeat (RC + 1) step(0, 0, 0, 0, 0);
    // R7 R11: requests held back to back
    repeat (12) step(1, 0, 20'hFFFFF, 0, 0);
    repeat (12) step(1, 1, 20'h00000, 0, 0);
    step(1, 0, 20'h00000, 0, 0); repeat (RC + 1) step(0, 0, 0, 0, 0);
    // R8 R9: retention, with a read waiting at release
    repeat (6) step(0, 0, 0, 0, 1);
    repeat (RC + 3) step(1, 0, 20'hFFFFF, 0, 0);
    // R10: retention raised during a write and a read
    step(1, 1, 20'h12345, 1, 0); repeat (3) step(0, 0, 0, 0, 1);
    repeat (4) step(0, 0, 0, 0, 0);
    step(1, 0, 20'h12345, 0, 0); step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 1);
    repeat (RC + 3) step(0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      automatic bit ret = ($urandom_range(0, 99) < 4) ? ~retain_req : retain_req;
      step($urandom_range(0, 9) < 7, $urandom_range(0, 1), pick($urandom_range(0, 7)),
           $urandom_range(0, 1), ret);
    end
    repeat (RC + 8) step(0, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule